// File: doc/BRIEF.md
# Circular and Bit-Reversed Pointer Update Unit

This unit keeps one data-memory pointer for a 16-bit byte-addressed data space of 32K words. After each completed access it moves the pointer to a new address. There are three ways to move it. Plain stepping adds a signed offset. Circular stepping keeps the pointer inside a start/end window: it wraps past the top of the window to the bottom, and past the bottom to the top. Reverse-carry stepping produces the shuffled address order that radix-2 FFT stages need. Because the wrap is done in hardware, software never checks buffer limits itself.

The same module is used twice in a system. The instance for the lower (X) region has reverse-carry stepping built in. The instance for the upper (Y) region is built without it, and only steps linearly or circularly. The address where the Y region starts is a parameter. The unit shows whether the current pointer lies in that region. The next pointer is formed by combinational logic. It is written into the pointer register on the clock edge where the access is marked complete.

Top module: `agu_unit`

## Requirements
- R1: After synchronous reset, `cur_addr` equals the parameter `RESET_ADDR` (default 0x0000).
- R2: When `ld_en` is 1 at a clock edge, `cur_addr` takes `ld_val`. This holds even when `adv` is also 1.
- R3: When both `ld_en` and `adv` are 0, `cur_addr` keeps its value.
- R4: When `circ_en` and the effective reverse enable are both 0, `nxt_addr` = `cur_addr` + `step` modulo 2^16. Here `step` is a two's-complement byte offset, and bit 0 is carried through unchanged.
- R5: In circular mode with a non-negative `step`, if `cur_addr`+`step` is above `win_hi`, then `nxt_addr` = `cur_addr`+`step` − (`win_hi` − `win_lo` + 2). Here `win_hi` is the byte address of the last word in the window.
- R6: In circular mode with a negative `step`, if `cur_addr`+`step` is below `win_lo`, then `nxt_addr` = `cur_addr`+`step` + (`win_hi` − `win_lo` + 2).
- R7: In circular mode, a sum that stays inside [`win_lo`, `win_hi`] is used as is. Bit 0 of `nxt_addr` is 0 in both circular and reverse-carry modes.
- R8: In reverse-carry mode, the word address `cur_addr[15:1]` is added to `rev_inc[15:1]`. Carries travel from the most significant bit toward bit 1, and a carry out of bit 1 is dropped. `step` has no effect, and `nxt_addr[0]` is 0. For a buffer of N words (N a power of two, 2 to 1024), `rev_inc` holds N.
- R9: When `brev_en` and `circ_en` are both 1 on a unit built with reverse-carry stepping, reverse-carry stepping is used.
- R10: On a unit built with `HAS_BITREV` = 0, `brev_en` and `rev_inc` have no effect. The unit steps linearly or circularly, as `circ_en` selects.
- R11: `cur_in_y` is 1 exactly when `cur_addr` ≥ the parameter `Y_SPLIT` (default 0x8000).
- R12: When `adv` is 1 and `ld_en` is 0, `cur_addr` after the edge equals the `nxt_addr` seen before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load `ld_val` into the pointer |
| ld_val | input | 16 | Value to load |
| adv | input | 1 | Access complete; move the pointer to `nxt_addr` |
| step | input | 16 | Signed byte offset for linear and circular modes |
| circ_en | input | 1 | Enable circular stepping |
| brev_en | input | 1 | Enable reverse-carry stepping (only with `HAS_BITREV`) |
| win_lo | input | 16 | First byte address of the circular window |
| win_hi | input | 16 | Byte address of the last word in the window |
| rev_inc | input | 16 | Reverse-carry increment (buffer size in words) |
| nxt_addr | output | 16 | Combinational next pointer |
| cur_addr | output | 16 | Registered pointer |
| cur_in_y | output | 1 | Pointer is in the Y region |

## Verification
The window-containment property assumes several things about the inputs. The window is word aligned, with `win_lo` ≤ `win_hi`. The pointer is even and lies inside the window. The step magnitude is no larger than the window length. The property is gated on exactly these conditions, so it does not fire when any of them is broken. Every circular vector in the bench uses an even 16- or 32-byte window, steps of 2 to 6 bytes, and a pointer loaded from inside the window. Every reverse-carry vector uses a power-of-two increment and a pointer aligned to a buffer of that size.

// File: rtl/agu_pkg.sv
package agu_pkg;
    localparam int AGU_AW = 16;
    localparam int AGU_WW = AGU_AW - 1;
    localparam int AGU_EW = AGU_AW + 2;

    typedef logic [AGU_AW-1:0] addr_t;
    typedef logic [AGU_WW-1:0] word_t;

    typedef enum logic [1:0] {
        STEP_LINEAR = 2'd0,
        STEP_CIRC   = 2'd1,
        STEP_BREV   = 2'd2
    } step_mode_e;

    typedef struct packed {
        addr_t lo;
        addr_t hi;
    } window_t;

    function automatic word_t flip_word(word_t v);
        word_t r;
        for (int i = 0; i < AGU_WW; i++) begin
            r[i] = v[AGU_WW-1-i];
        end
        return r;
    endfunction
endpackage

// File: rtl/agu_circ_step.sv
module agu_circ_step
    import agu_pkg::*;
(
    input  addr_t   cur,
    input  addr_t   step,
    input  window_t win,
    output addr_t   res
);
    logic signed [AGU_EW-1:0] sum;
    logic signed [AGU_EW-1:0] lo_x;
    logic signed [AGU_EW-1:0] hi_x;
    logic signed [AGU_EW-1:0] len;
    logic signed [AGU_EW-1:0] fixed;

    always_comb begin
        sum  = $signed({2'b00, cur}) + $signed({{2{step[AGU_AW-1]}}, step});
        lo_x = $signed({2'b00, win.lo});
        hi_x = $signed({2'b00, win.hi});
        len  = hi_x - lo_x + AGU_EW'(2);
        if (!step[AGU_AW-1] && (sum > hi_x)) begin
            fixed = sum - len;
        end else if (step[AGU_AW-1] && (sum < lo_x)) begin
            fixed = sum + len;
        end else begin
            fixed = sum;
        end
        res = {fixed[AGU_AW-1:1], 1'b0};
    end
endmodule

// File: rtl/agu_brev_step.sv
module agu_brev_step
    import agu_pkg::*;
(
    input  addr_t cur,
    input  addr_t inc,
    output addr_t res
);
    word_t wsum;
    logic  unused_lsbs;

    always_comb begin
        wsum = flip_word(flip_word(cur[AGU_AW-1:1]) + flip_word(inc[AGU_AW-1:1]));
        res  = {wsum, 1'b0};
    end

    assign unused_lsbs = cur[0] ^ inc[0];
endmodule

// File: rtl/agu_unit.sv
module agu_unit
    import agu_pkg::*;
#(
    parameter bit    HAS_BITREV = 1'b1,
    parameter addr_t Y_SPLIT    = 16'h8000,
    parameter addr_t RESET_ADDR = 16'h0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_en,
    input  logic [15:0] ld_val,
    input  logic        adv,
    input  logic [15:0] step,
    input  logic        circ_en,
    input  logic        brev_en,
    input  logic [15:0] win_lo,
    input  logic [15:0] win_hi,
    input  logic [15:0] rev_inc,
    output logic [15:0] nxt_addr,
    output logic [15:0] cur_addr,
    output logic        cur_in_y
);
    addr_t      ptr_q;
    addr_t      lin_res;
    addr_t      circ_res;
    addr_t      brev_res;
    logic       brev_on;
    window_t    win;
    step_mode_e mode;

    assign win.lo  = win_lo;
    assign win.hi  = win_hi;
    assign lin_res = ptr_q + step;

    agu_circ_step u_circ (
        .cur  (ptr_q),
        .step (step),
        .win  (win),
        .res  (circ_res)
    );

    generate
        if (HAS_BITREV) begin : g_brev
            agu_brev_step u_brev (
                .cur (ptr_q),
                .inc (rev_inc),
                .res (brev_res)
            );
            assign brev_on = brev_en;
        end else begin : g_no_brev
            logic unused_brev;
            assign unused_brev = brev_en ^ (^rev_inc);
            assign brev_res    = '0;
            assign brev_on     = 1'b0;
        end
    endgenerate

    always_comb begin
        if (brev_on) begin
            mode = STEP_BREV;
        end else if (circ_en) begin
            mode = STEP_CIRC;
        end else begin
            mode = STEP_LINEAR;
        end
        case (mode)
            STEP_BREV: nxt_addr = brev_res;
            STEP_CIRC: nxt_addr = circ_res;
            default:   nxt_addr = lin_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= RESET_ADDR;
        end else if (ld_en) begin
            ptr_q <= ld_val;
        end else if (adv) begin
            ptr_q <= nxt_addr;
        end
    end

    assign cur_addr = ptr_q;
    assign cur_in_y = (ptr_q >= Y_SPLIT);
endmodule

// File: rtl/agu_unit_chk.sv
module agu_unit_chk #(
    parameter bit HAS_BITREV = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        ld_en,
    input logic [15:0] ld_val,
    input logic        adv,
    input logic [15:0] step,
    input logic        circ_en,
    input logic        brev_en,
    input logic [15:0] win_lo,
    input logic [15:0] win_hi,
    input logic [15:0] nxt_addr,
    input logic [15:0] cur_addr
);
    logic [15:0] smag;
    logic [16:0] wlen;
    logic        in_win;
    logic        brev_eff;

    always_comb begin
        smag     = step[15] ? (16'h0 - step) : step;
        wlen     = {1'b0, win_hi} - {1'b0, win_lo} + 17'd2;
        brev_eff = HAS_BITREV && brev_en;
        in_win   = (win_lo <= win_hi) && !win_lo[0] && !win_hi[0] && !cur_addr[0]
                 && (cur_addr >= win_lo) && (cur_addr <= win_hi)
                 && ({1'b0, smag} <= wlen);
    end

    p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> cur_addr == $past(ld_val));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!ld_en && !adv) |=> $stable(cur_addr));

    p_adv_takes_next_r12: assert property (@(posedge clk) disable iff (rst)
        (adv && !ld_en) |=> cur_addr == $past(nxt_addr));

    p_even_result_r7: assert property (@(posedge clk) disable iff (rst)
        (circ_en || brev_eff) |-> !nxt_addr[0]);

    // R5 and R6: circular results stay inside the window
    p_stay_in_window_r5: assert property (@(posedge clk) disable iff (rst)
        (circ_en && !brev_eff && in_win) |-> (nxt_addr >= win_lo && nxt_addr <= win_hi));
endmodule

bind agu_unit agu_unit_chk #(.HAS_BITREV(HAS_BITREV)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ld_en    (ld_en),
    .ld_val   (ld_val),
    .adv      (adv),
    .step     (step),
    .circ_en  (circ_en),
    .brev_en  (brev_en),
    .win_lo   (win_lo),
    .win_hi   (win_hi),
    .nxt_addr (nxt_addr),
    .cur_addr (cur_addr)
);

// File: tb/agu_unit_test.sv
module agu_unit_test;
    localparam int CLK_P  = 10;
    localparam int WD_CYC = 5000;
    localparam int NVEC   = 14;

    typedef struct packed {
        logic [15:0] cur;
        logic [15:0] stp;
        logic        circ;
        logic        brev;
        logic [15:0] lo;
        logic [15:0] hi;
        logic [15:0] rinc;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        '{16'h1000, 16'h0002, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h1002, 8'd4},  // R4
        '{16'h0000, 16'hFFFE, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'hFFFE, 8'd4},  // R4
        '{16'h1001, 16'h0001, 1'b0, 1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h1002, 8'd4},  // R4
        '{16'h0804, 16'h0004, 1'b1, 1'b0, 16'h0800, 16'h081E, 16'h0000, 16'h0808, 8'd7},  // R7
        '{16'h081E, 16'h0002, 1'b1, 1'b0, 16'h0800, 16'h081E, 16'h0000, 16'h0800, 8'd5},  // R5
        '{16'h081C, 16'h0006, 1'b1, 1'b0, 16'h0800, 16'h081E, 16'h0000, 16'h0802, 8'd5},  // R5
        '{16'h0800, 16'hFFFE, 1'b1, 1'b0, 16'h0800, 16'h081E, 16'h0000, 16'h081E, 8'd6},  // R6
        '{16'h0802, 16'hFFFA, 1'b1, 1'b0, 16'h0800, 16'h081E, 16'h0000, 16'h081C, 8'd6},  // R6
        '{16'h0800, 16'h0100, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0008, 16'h0808, 8'd8},  // R8
        '{16'h0808, 16'h0100, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0008, 16'h0804, 8'd8},  // R8
        '{16'h080E, 16'h0100, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0008, 16'h0800, 8'd8},  // R8
        '{16'h0804, 16'h0002, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0008, 16'h080C, 8'd8},  // R8
        '{16'h080C, 16'h0002, 1'b1, 1'b1, 16'h0800, 16'h080E, 16'h0008, 16'h0802, 8'd9},  // R9
        '{16'h0000, 16'h0002, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0400, 16'h0400, 8'd8}   // R8
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en;
    logic [15:0] ld_val;
    logic        adv;
    logic [15:0] step;
    logic        circ_en;
    logic        brev_en;
    logic [15:0] win_lo;
    logic [15:0] win_hi;
    logic [15:0] rev_inc;
    logic [15:0] nxt_addr;
    logic [15:0] cur_addr;
    logic        cur_in_y;
    logic [15:0] y_nxt;
    logic [15:0] y_cur;
    logic        y_in_y;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    agu_unit uut (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_val(ld_val), .adv(adv),
        .step(step), .circ_en(circ_en), .brev_en(brev_en), .win_lo(win_lo),
        .win_hi(win_hi), .rev_inc(rev_inc), .nxt_addr(nxt_addr),
        .cur_addr(cur_addr), .cur_in_y(cur_in_y)
    );

    agu_unit #(.HAS_BITREV(1'b0)) uut_y (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_val(ld_val), .adv(adv),
        .step(step), .circ_en(circ_en), .brev_en(brev_en), .win_lo(win_lo),
        .win_hi(win_hi), .rev_inc(rev_inc), .nxt_addr(y_nxt),
        .cur_addr(y_cur), .cur_in_y(y_in_y)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic load(input logic [15:0] v);
        @(negedge clk);
        ld_en  = 1'b1;
        ld_val = v;
        adv    = 1'b0;
        @(negedge clk);
        ld_en  = 1'b0;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            report();
        end
    end

    initial begin
        rst = 1'b1; ld_en = 1'b0; ld_val = '0; adv = 1'b0; step = '0;
        circ_en = 1'b0; brev_en = 1'b0; win_lo = '0; win_hi = '0; rev_inc = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset value
        chk("R1 reset", cur_addr, 16'h0000);
        chk("R1 reset in_y", {15'd0, cur_in_y}, 16'h0000);

        // vector table walk
        for (int i = 0; i < NVEC; i++) begin
            load(TBL[i].cur);
            step    = TBL[i].stp;
            circ_en = TBL[i].circ;
            brev_en = TBL[i].brev;
            win_lo  = TBL[i].lo;
            win_hi  = TBL[i].hi;
            rev_inc = TBL[i].rinc;
            adv     = 1'b1;
            #1;
            chk($sformatf("R%0d vec %0d nxt", TBL[i].req, i), nxt_addr, TBL[i].exp);
            @(negedge clk);
            adv = 1'b0;
            // R12: registered value equals the next pointer seen before the edge
            chk($sformatf("R12 vec %0d cur", i), cur_addr, TBL[i].exp);
        end

        // R10: unit without reverse-carry ignores brev_en and rev_inc
        load(16'h080C);
        step = 16'h0002; circ_en = 1'b1; brev_en = 1'b1;
        win_lo = 16'h0800; win_hi = 16'h080E; rev_inc = 16'h0008;
        adv = 1'b1;
        @(negedge clk);
        adv = 1'b0;
        chk("R10 y circ", y_cur, 16'h080E);
        load(16'h080E);
        circ_en = 1'b0;
        adv = 1'b1;
        @(negedge clk);
        adv = 1'b0;
        chk("R10 y linear", y_cur, 16'h0810);
        chk("R10 x brev", cur_addr, 16'h0801 & 16'hFFFE);

        // R2: load wins over advance
        @(negedge clk);
        ld_en = 1'b1; ld_val = 16'h1234; adv = 1'b1;
        @(negedge clk);
        ld_en = 1'b0; adv = 1'b0;
        chk("R2 load priority", cur_addr, 16'h1234);

        // R3: hold with no load or advance
        step = 16'h0040; circ_en = 1'b0; brev_en = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 hold", cur_addr, 16'h1234);

        // R11: region flag on both sides of the split
        load(16'h7FFE);
        chk("R11 below split", {15'd0, cur_in_y}, 16'h0000);
        load(16'h8000);
        chk("R11 at split", {15'd0, cur_in_y}, 16'h0001);

        // R1: reset again from a loaded state
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 re-reset", cur_addr, 16'h0000);

        report();
    end
endmodule